// File: doc/BRIEF.md
# CCD Frame and Line Timing Sequencer

This block drives the readout timing of an interline CCD from a 40 MHz system clock. A start request opens an exposure window. The window lasts a programmed number of 1 ms units, and `integrate_o` is high for all of it. When the window closes, the block reads out one full frame and then returns to idle.

Pixels run at half the system rate. Each line opens with a vertical transfer interval in which the horizontal clocks are stopped. That interval has three parts: a one-pixel pause, a 35-pixel V2 pulse and a 31-pixel resume delay. The horizontal clocks then run for 1992 active pixels and 24 overclock pixels. A frame is 1214 sensor lines plus 6 overclock lines. A single-cycle `frame_done_o` marks the end of the frame.

Every duration is a parameter. The defaults give the figures above: 67 + 2016 = 2083 pixel times per line, and 40,000 system clocks per integration unit.

Top module: `ccd_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, all outputs are low until a start is accepted.
- R2: A `start_i` pulse in idle with `int_units_i` nonzero raises `integrate_o` on the next clock. It then stays high for exactly `int_units_i` × TICK_CLKS system clocks (TICK_CLKS defaults to 40,000, which is 1 ms at 40 MHz).
- R3: `start_i` has no effect in three cases: when `int_units_i` is zero, during exposure, and during readout. Exposure length and frame timing are unchanged by it.
- R4: Readout starts in the first cycle after `integrate_o` falls. With readout cycle index k counted from 0, `pix_en_o` is high when k is even, because one pixel is two system clocks.
- R5: Within a line, with p as the pixel index, `v2_o` is high for 1 ≤ p < 36. That is a one-pixel pause followed by a 35-pixel pulse.
- R6: `hclk_en_o` is low for p < 67, which includes a 31-pixel resume delay after V2 falls. It is high for 67 ≤ p < 2083, so a line is 2083 pixel times.
- R7: `line_valid_o` is high only for 67 ≤ p < 67 + 1992, and only on lines 0 to 1213. It is low on overclock pixels and on the 6 overclock lines.
- R8: A frame is 1220 lines. `frame_done_o` is high for exactly one cycle, the cycle after the last pixel of the last line. The block is then idle and accepts a new start.
- R9: `v2_o` and `hclk_en_o` are never high together. `line_valid_o` is never high without `hclk_en_o`.
- R10: An asynchronous reset during readout forces all outputs low at once. A later start runs a complete, correct frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (40 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request exposure plus frame readout |
| int_units_i | input | UNIT_W | Exposure length in 1 ms units |
| pix_en_o | output | 1 | Pixel-rate strobe, first system clock of each pixel |
| hclk_en_o | output | 1 | Horizontal clock gating, high while H clocks run |
| v2_o | output | 1 | Vertical transfer pulse |
| line_valid_o | output | 1 | Active pixel of a sensor line |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |
| integrate_o | output | 1 | High for the exposure window |

## Verification
Three pairs of events can land in the same clock edge. The last unit tick of the exposure coincides with the launch of readout. The last pixel of a line coincides with the wrap of the line counter. The last pixel of the frame coincides with the return to idle. The bench uses shortened parameters so that each of these boundaries is crossed many times. In every cycle it compares the outputs against a model built from the pixel index, the line index and the half-pixel phase. It requires `pix_en_o` in the very cycle after `integrate_o` falls, and `frame_done_o` exactly one cycle after the final pixel. Start pulses are also injected during exposure and during readout, and both timelines must stay unchanged.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_EXPOSE = 2'd1,
    SEQ_READ   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ccd_seq_exposure.sv
module ccd_seq_exposure #(
  parameter int TICK_CLKS = 40000,
  parameter int UNIT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [UNIT_W-1:0] units_i,
  output logic              active_o,
  output logic              last_o
);
  localparam int TICK_W = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(TICK_CLKS - 1);

  logic [TICK_W-1:0] tick_q;
  logic [UNIT_W-1:0] unit_q;
  logic              active_q;
  logic              tick_wrap;

  assign tick_wrap = (tick_q == TICK_MAX);
  assign active_o  = active_q;
  assign last_o    = active_q && tick_wrap && (unit_q == UNIT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q   <= '0;
      unit_q   <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      tick_q   <= '0;
      unit_q   <= units_i;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (tick_wrap) begin
        tick_q <= '0;
        if (unit_q == UNIT_W'(1)) active_q <= 1'b0;
        else                      unit_q   <= unit_q - UNIT_W'(1);
      end else begin
        tick_q <= tick_q + TICK_W'(1);
      end
    end
  end
endmodule

// File: rtl/ccd_seq_line.sv
module ccd_seq_line #(
  parameter int CLKS_PER_PIX = 2,
  parameter int PRE_PIX      = 1,
  parameter int XFER_PIX     = 35,
  parameter int POST_PIX     = 31,
  parameter int ACT_PIX      = 1992,
  parameter int OVER_PIX     = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic pix_en_o,
  output logic hclk_en_o,
  output logic v2_o,
  output logic act_pix_o,
  output logic line_end_o
);
  localparam int HOLD_PIX = PRE_PIX + XFER_PIX + POST_PIX;
  localparam int LINE_PIX = HOLD_PIX + ACT_PIX + OVER_PIX;
  localparam int POS_W    = $clog2(LINE_PIX);
  localparam logic [POS_W-1:0] V2_ON    = POS_W'(PRE_PIX);
  localparam logic [POS_W-1:0] V2_OFF   = POS_W'(PRE_PIX + XFER_PIX);
  localparam logic [POS_W-1:0] H_ON     = POS_W'(HOLD_PIX);
  localparam logic [POS_W-1:0] ACT_END  = POS_W'(HOLD_PIX + ACT_PIX);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(LINE_PIX - 1);

  logic             pix_first;
  logic             pix_last;
  logic [POS_W-1:0] pos_q;

  generate
    if (CLKS_PER_PIX > 1) begin : g_div
      localparam int DIV_W = $clog2(CLKS_PER_PIX);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   div_q <= '0;
        else if (!run_i)                               div_q <= '0;
        else if (div_q == DIV_W'(CLKS_PER_PIX - 1))    div_q <= '0;
        else                                           div_q <= div_q + DIV_W'(1);
      end
      assign pix_first = (div_q == '0);
      assign pix_last  = (div_q == DIV_W'(CLKS_PER_PIX - 1));
    end else begin : g_nodiv
      assign pix_first = 1'b1;
      assign pix_last  = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= '0;
    else if (!run_i)   pos_q <= '0;
    else if (pix_last) pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + POS_W'(1);
  end

  assign pix_en_o   = run_i && pix_first;
  assign v2_o       = run_i && (pos_q >= V2_ON) && (pos_q < V2_OFF);
  assign hclk_en_o  = run_i && (pos_q >= H_ON);
  assign act_pix_o  = run_i && (pos_q >= H_ON) && (pos_q < ACT_END);
  assign line_end_o = run_i && pix_last && (pos_q == POS_LAST);
endmodule

// File: rtl/ccd_seq_frame.sv
module ccd_seq_frame #(
  parameter int ACT_LINES  = 1214,
  parameter int OVER_LINES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic line_end_i,
  output logic act_line_o,
  output logic frame_last_o,
  output logic done_o
);
  localparam int FRAME_LINES = ACT_LINES + OVER_LINES;
  localparam int LN_W        = $clog2(FRAME_LINES);
  localparam logic [LN_W-1:0] LN_LAST = LN_W'(FRAME_LINES - 1);

  logic [LN_W-1:0] line_q;
  logic            done_q;

  assign frame_last_o = line_end_i && (line_q == LN_LAST);
  assign act_line_o   = (line_q < LN_W'(ACT_LINES));
  assign done_o       = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= frame_last_o;
      if (!run_i)          line_q <= '0;
      else if (line_end_i) line_q <= (line_q == LN_LAST) ? '0 : line_q + LN_W'(1);
    end
  end
endmodule

// File: rtl/ccd_seq.sv
module ccd_seq
  import ccd_seq_pkg::*;
#(
  parameter int CLKS_PER_PIX = 2,
  parameter int PRE_PIX      = 1,
  parameter int XFER_PIX     = 35,
  parameter int POST_PIX     = 31,
  parameter int ACT_PIX      = 1992,
  parameter int OVER_PIX     = 24,
  parameter int ACT_LINES    = 1214,
  parameter int OVER_LINES   = 6,
  parameter int TICK_CLKS    = 40000,
  parameter int UNIT_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [UNIT_W-1:0] int_units_i,
  output logic              pix_en_o,
  output logic              hclk_en_o,
  output logic              v2_o,
  output logic              line_valid_o,
  output logic              frame_done_o,
  output logic              integrate_o
);
  seq_state_e state_q, state_d;
  logic start_ok, exp_active, exp_last, run;
  logic act_pix, act_line, line_end, frame_last;

  assign start_ok = (state_q == SEQ_IDLE) && start_i && (int_units_i != '0);
  assign run      = (state_q == SEQ_READ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (start_ok)   state_d = SEQ_EXPOSE;
      SEQ_EXPOSE: if (exp_last)   state_d = SEQ_READ;
      SEQ_READ:   if (frame_last) state_d = SEQ_IDLE;
      default:                    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  ccd_seq_exposure #(
    .TICK_CLKS(TICK_CLKS),
    .UNIT_W   (UNIT_W)
  ) u_exposure (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .units_i (int_units_i),
    .active_o(exp_active),
    .last_o  (exp_last)
  );

  ccd_seq_line #(
    .CLKS_PER_PIX(CLKS_PER_PIX),
    .PRE_PIX     (PRE_PIX),
    .XFER_PIX    (XFER_PIX),
    .POST_PIX    (POST_PIX),
    .ACT_PIX     (ACT_PIX),
    .OVER_PIX    (OVER_PIX)
  ) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .pix_en_o  (pix_en_o),
    .hclk_en_o (hclk_en_o),
    .v2_o      (v2_o),
    .act_pix_o (act_pix),
    .line_end_o(line_end)
  );

  ccd_seq_frame #(
    .ACT_LINES (ACT_LINES),
    .OVER_LINES(OVER_LINES)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .line_end_i  (line_end),
    .act_line_o  (act_line),
    .frame_last_o(frame_last),
    .done_o      (frame_done_o)
  );

  assign integrate_o  = exp_active;
  assign line_valid_o = act_pix && act_line;
endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pix_en_o,
  input logic hclk_en_o,
  input logic v2_o,
  input logic line_valid_o,
  input logic frame_done_o,
  input logic integrate_o
);
  assert_v2_hclk_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(v2_o && hclk_en_o));

  assert_lv_needs_hclk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> hclk_en_o);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  assert_expose_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    integrate_o |-> !(pix_en_o || hclk_en_o || v2_o || frame_done_o));

  assert_readout_launch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(integrate_o) |-> (pix_en_o && !v2_o && !hclk_en_o));

  assert_v2_rise_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(v2_o) |-> (!hclk_en_o && $past(!hclk_en_o)));
endmodule

bind ccd_seq ccd_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_en_o    (pix_en_o),
  .hclk_en_o   (hclk_en_o),
  .v2_o        (v2_o),
  .line_valid_o(line_valid_o),
  .frame_done_o(frame_done_o),
  .integrate_o (integrate_o)
);

// File: tb/ccd_seq_bench.sv
module ccd_seq_bench;
  localparam int PRE = 1, XFER = 3, POST = 2, ACT = 5, OVER = 2;
  localparam int ALN = 3, OLN = 2, TICK = 4, UW = 8;
  localparam int HOLD  = PRE + XFER + POST;
  localparam int LP    = HOLD + ACT + OVER;
  localparam int FRAME = 2 * LP * (ALN + OLN);

  localparam int NV = 4;
  localparam int VEC_UNITS [NV] = '{1, 3, 0, 2};
  localparam int VEC_HIGH  [NV] = '{4, 12, 0, 8};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [UW-1:0] units = '0;
  logic pix_en, hclk_en, v2, lv, done, integ;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ccd_seq #(
    .CLKS_PER_PIX(2), .PRE_PIX(PRE), .XFER_PIX(XFER), .POST_PIX(POST),
    .ACT_PIX(ACT), .OVER_PIX(OVER), .ACT_LINES(ALN), .OVER_LINES(OLN),
    .TICK_CLKS(TICK), .UNIT_W(UW)
  ) u_ccd_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .int_units_i(units),
    .pix_en_o(pix_en), .hclk_en_o(hclk_en), .v2_o(v2),
    .line_valid_o(lv), .frame_done_o(done), .integrate_o(integ)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {28'd0, pix_en, hclk_en, v2, lv} | (int'(done) << 4) | (int'(integ) << 5);
  endfunction

  // poke: pulse start during exposure and during readout (must be ignored)
  task automatic run_vec(input int u, input int exp_hi, input bit poke);
    int hi;
    @(negedge clk); start = 1'b1; units = UW'(u);
    @(negedge clk); start = 1'b0;
    if (exp_hi == 0) begin
      bit quiet = 1'b1;
      for (int i = 0; i < 3 * TICK; i++) begin
        if (outs() != 0) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R3 zero units ignored", outs(), 0);
      return;
    end
    hi = 0;
    while (integ && hi < 1000) begin
      if (poke && hi == 2) begin start = 1'b1; units = 8'd9; end
      else start = 1'b0;
      hi++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(hi == exp_hi, poke ? "R3 exposure unchanged" : "R2 integrate length", hi, exp_hi);
    for (int k = 0; k < FRAME; k++) begin
      int p  = (k / 2) % LP;
      int ln = k / (2 * LP);
      bit e_pix = (k % 2) == 0;
      bit e_v2  = (p >= PRE) && (p < PRE + XFER);
      bit e_h   = (p >= HOLD);
      bit e_lv  = e_h && (p < HOLD + ACT) && (ln < ALN);
      chk(pix_en == e_pix, "R4 pix_en", pix_en, e_pix);
      chk(v2 == e_v2, "R5 v2", v2, e_v2);
      chk(hclk_en == e_h, "R6 hclk_en", hclk_en, e_h);
      chk(lv == e_lv, "R7 line_valid", lv, e_lv);
      chk(!done && !integ, "R8 no early done", outs(), 0);
      if (poke && k == 7) begin start = 1'b1; units = 8'd1; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done && !pix_en && !hclk_en && !v2, "R8 frame_done", outs(), 16);
    @(negedge clk);
    chk(outs() == 0, poke ? "R3 idle after poked frame" : "R8 idle after done", outs(), 0);
  endtask

  initial begin
    units = '0;
    #3;
    chk(outs() == 0, "R1 outputs in reset", outs(), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(outs() == 0, "R1 idle after reset", outs(), 0);

    for (int v = 0; v < NV; v++) run_vec(VEC_UNITS[v], VEC_HIGH[v], 1'b0);

    // R3: starts during exposure and readout ignored
    run_vec(2, 8, 1'b1);

    // R10: async reset mid-readout, then a clean frame
    @(negedge clk); start = 1'b1; units = 8'd1;
    @(negedge clk); start = 1'b0;
    repeat (TICK + 40) @(negedge clk);
    chk(hclk_en || v2 || pix_en, "R10 readout in progress", outs(), 1);
    #1 rst_n = 1'b0;
    #1 chk(outs() == 0, "R10 async reset clears outputs", outs(), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(outs() == 0, "R10 idle after reset", outs(), 0);
    run_vec(1, 4, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule